// File: doc/BRIEF.md
# Half-Offset Fractional Divide Controller

This block steers the integer counter that divides one reference clock. Each divided period it chooses the length of the next period. A second-order error-feedback modulator dithers that length around an integer part N. The long-run ratio is N + 1/2 + F/(2M), where M is a modulus and F is a signed fraction with |F| < M. The half-integer offset lets a symmetric signed fraction reach ratios on either side of N + 1/2 without changing N.

Three selections exist:
- **Integer mode.** The modulator is off, and every period is exactly N.
- **Fractional mode.** The modulator is on.
- **Low-rate mode.** This mode overrides the other two. It divides by 1, 2 or 4 only, and the modulator is held idle.

An optional pseudorandom bit can be folded into the modulator input to break up periodic patterns. Parameter inputs are sampled only at the boundary of a divided period.

Internally, the modulator is a cascade of two first-order accumulators. Both run over an effective modulus 2M with numerator M + F. The divided pulse the block emits is the same pulse that steps the modulator.

Top module: `halfoff_frac_div`

## Requirements
- R1: While rst_ni is low, div_val_o reads 1 and div_pulse_o is high. The first divided pulse therefore falls in the first cycle after reset is released.
- R2: Two consecutive pulses on div_pulse_o are exactly div_val_o clock cycles apart. Here div_val_o is the value held in the period that follows the earlier pulse, and it stays constant within that period.
- R3: With low_rate_i=0 and sdm_en_i=0, every period lasts int_i cycles, for int_i from 1 to 63. An int_i of 0 is treated as 1.
- R4: With low_rate_i=0, sdm_en_i=1 and dither_en_i=0, the accumulators start from zero after reset. With K = M + F, the sum of the first t periods after that start is either t·N + floor(t·K/(2M)) or that value plus 1.
- R5: In fractional mode, each period lies in [N−1, N+2], where N is the effective integer part. The upper end is capped at 63.
- R6: In fractional mode, an int_i below 4 acts as 4.
- R7: With dither_en_i=1, a 15-bit maximal-length shift register adds 0 or 1 to the numerator on each modulator step. Periods still obey R5. Over 200 periods with M=5, F=0 and N=6, the sum is at least 1302.
- R8: With low_rate_i=1, the period is set by low_sel_i: 00 gives 1, 01 gives 2, and 1x gives 4. This holds whatever the values of sdm_en_i and int_i.
- R9: Parameter inputs that change in the middle of a period do not alter that period. Values present in the cycle where div_pulse_o is high set the next period.
- R10: Leaving fractional mode clears both accumulators. After fractional mode is re-entered at a pulse, the period sequence repeats the sequence seen after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_i | input | INT_W | Integer part N |
| mod_i | input | MOD_W | Modulus M, at least 1 |
| frac_i | input | MOD_W+1 | Signed fraction F, with abs(F) < M |
| sdm_en_i | input | 1 | Selects fractional mode |
| dither_en_i | input | 1 | Folds the pseudorandom bit into the numerator |
| low_rate_i | input | 1 | Selects low-rate mode, which overrides the other modes |
| low_sel_i | input | 2 | Ratio select for low-rate mode |
| div_val_o | output | INT_W | Length of the current divided period |
| div_pulse_o | output | 1 | High in the last cycle of each divided period |

## Verification
Two events can land on the same clock edge: a parameter change and the counter reload at a period boundary. The bench provokes both orders. It changes int_i in the middle of a period and checks that the running period keeps its old length. It then changes int_i in the very cycle where the pulse is high, and expects the new value to govern the next period at once.

The same collision is used for the modulator. fractional mode is switched off and back on exactly at pulse cycles. The periods that follow are compared with the sequence recorded just after reset, which shows that the clear and the first new step happened in the intended order.

// File: rtl/hfd_pkg.sv
package hfd_pkg;
  typedef enum logic [1:0] {
    MODE_INT  = 2'd0,
    MODE_FRAC = 2'd1,
    MODE_LOW  = 2'd2
  } div_mode_e;

  localparam int unsigned FRAC_MIN_INT = 4;
  localparam int unsigned PRBS_W       = 15;
endpackage

// File: rtl/hfd_prbs.sv
module hfd_prbs #(
  parameter int unsigned W = hfd_pkg::PRBS_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic bit_o
);
  logic [W-1:0] sr_q;
  logic         fb;

  // taps W and W-1: maximal length for W = 15
  assign fb    = sr_q[W-1] ^ sr_q[W-2];
  assign bit_o = sr_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '1;
    else if (adv_i) sr_q <= {sr_q[W-2:0], fb};
  end
endmodule

// File: rtl/hfd_mash.sv
module hfd_mash #(
  parameter int unsigned AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [AW-1:0] q_i,
  input  logic [AW-1:0] k_i,
  output logic [2:0]    y_o
);
  logic [AW-1:0] acc1_q, acc2_q;
  logic [AW-1:0] sum1, sum2, acc1_n, acc2_n;
  logic          c1, c2, c2_q;

  always_comb begin
    sum1   = acc1_q + k_i;
    c1     = (sum1 >= q_i);
    acc1_n = c1 ? sum1 - q_i : sum1;
    sum2   = acc2_q + acc1_n;
    c2     = (sum2 >= q_i);
    acc2_n = c2 ? sum2 - q_i : sum2;
    // second stage is differentiated once: y = c1 + c2 - c2[n-1]
    y_o    = {2'b00, c1} + {2'b00, c2} - {2'b00, c2_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc1_q <= '0;
      acc2_q <= '0;
      c2_q   <= 1'b0;
    end else if (clr_i) begin
      acc1_q <= '0;
      acc2_q <= '0;
      c2_q   <= 1'b0;
    end else if (step_i) begin
      acc1_q <= acc1_n;
      acc2_q <= acc2_n;
      c2_q   <= c2;
    end
  end
endmodule

// File: rtl/hfd_counter.sv
module hfd_counter #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] val_o,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q, val_q;

  assign pulse_o = (cnt_q == val_q - W'(1));
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      val_q <= W'(1);
    end else if (pulse_o) begin
      cnt_q <= '0;
      val_q <= load_val_i;
    end else begin
      cnt_q <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/halfoff_frac_div.sv
module halfoff_frac_div
  import hfd_pkg::*;
#(
  parameter int unsigned INT_W = 6,
  parameter int unsigned MOD_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INT_W-1:0] int_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [MOD_W:0]   frac_i,
  input  logic             sdm_en_i,
  input  logic             dither_en_i,
  input  logic             low_rate_i,
  input  logic [1:0]       low_sel_i,
  output logic [INT_W-1:0] div_val_o,
  output logic             div_pulse_o
);
  localparam int unsigned AW      = MOD_W + 2;
  localparam int unsigned VW      = INT_W + 2;
  localparam int unsigned DIV_MAX = (1 << INT_W) - 1;

  div_mode_e        mode;
  logic [AW-1:0]    q_eff, k_eff;
  logic [2:0]       y;
  logic             prbs_bit, dith, step, clr;
  logic [INT_W-1:0] n_frac, next_val;
  logic [VW-1:0]    v;

  always_comb begin
    if (low_rate_i)    mode = MODE_LOW;
    else if (sdm_en_i) mode = MODE_FRAC;
    else               mode = MODE_INT;
  end

  assign step  = div_pulse_o && (mode == MODE_FRAC);
  assign clr   = (mode != MODE_FRAC);
  assign dith  = dither_en_i & prbs_bit;
  // effective modulus 2M, numerator M + F (+ dither)
  assign q_eff = {1'b0, mod_i, 1'b0};
  assign k_eff = {2'b00, mod_i} + {frac_i[MOD_W], frac_i} + {{(AW-1){1'b0}}, dith};

  hfd_prbs #(.W(PRBS_W)) u_prbs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (step & dither_en_i),
    .bit_o  (prbs_bit)
  );

  hfd_mash #(.AW(AW)) u_mash (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (step),
    .q_i    (q_eff),
    .k_i    (k_eff),
    .y_o    (y)
  );

  always_comb begin
    n_frac = (int_i < INT_W'(FRAC_MIN_INT)) ? INT_W'(FRAC_MIN_INT) : int_i;
    v      = {2'b00, n_frac} + {{(VW-3){y[2]}}, y};
    unique case (mode)
      MODE_LOW: begin
        case (low_sel_i)
          2'b00:   next_val = INT_W'(1);
          2'b01:   next_val = INT_W'(2);
          default: next_val = INT_W'(4);
        endcase
      end
      MODE_FRAC: next_val = (v > VW'(DIV_MAX)) ? INT_W'(DIV_MAX) : v[INT_W-1:0];
      default:   next_val = (int_i == '0) ? INT_W'(1) : int_i;
    endcase
  end

  hfd_counter #(.W(INT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_val_i (next_val),
    .val_o      (div_val_o),
    .pulse_o    (div_pulse_o)
  );
endmodule

// File: rtl/hfd_checker.sv
module hfd_checker #(
  parameter int unsigned INT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [INT_W-1:0] int_i,
  input logic             sdm_en_i,
  input logic             low_rate_i,
  input logic [1:0]       low_sel_i,
  input logic [INT_W-1:0] div_val_o,
  input logic             div_pulse_o
);
  localparam int DIV_MAX = (1 << INT_W) - 1;

  a_r2_hold_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_pulse_o |=> $stable(div_val_o));

  a_r2_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_val_o != '0);

  a_r3_int_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_pulse_o && !low_rate_i && !sdm_en_i && int_i != '0)
      |=> div_val_o == $past(int_i));

  a_r5_frac_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_pulse_o && !low_rate_i && sdm_en_i && int'(int_i) >= 4 && int'(int_i) <= DIV_MAX - 2)
      |=> (int'(div_val_o) + 1 >= int'($past(int_i))) && (int'(div_val_o) <= int'($past(int_i)) + 2));

  a_r8_low_ratio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_pulse_o && low_rate_i)
      |=> div_val_o == (($past(low_sel_i) == 2'b00) ? INT_W'(1) :
                        ($past(low_sel_i) == 2'b01) ? INT_W'(2) : INT_W'(4)));
endmodule

bind halfoff_frac_div hfd_checker #(.INT_W(INT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .int_i       (int_i),
  .sdm_en_i    (sdm_en_i),
  .low_rate_i  (low_rate_i),
  .low_sel_i   (low_sel_i),
  .div_val_o   (div_val_o),
  .div_pulse_o (div_pulse_o)
);

// File: tb/tb_halfoff_frac_div.sv
module tb_halfoff_frac_div;
  localparam time CLK_PERIOD = 10ns;
  localparam int  INT_W = 6;
  localparam int  MOD_W = 18;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [INT_W-1:0] int_i = '0;
  logic [MOD_W-1:0] mod_i = '0;
  logic [MOD_W:0]   frac_i = '0;
  logic             sdm_en_i = 1'b0, dither_en_i = 1'b0, low_rate_i = 1'b0;
  logic [1:0]       low_sel_i = '0;
  logic [INT_W-1:0] div_val_o;
  logic             div_pulse_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  halfoff_frac_div #(.INT_W(INT_W), .MOD_W(MOD_W)) dut (.*);

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic start(int n, int m, int f, bit sdm, bit dith, bit low, int sel);
    rst_ni = 1'b0;
    int_i = INT_W'(n); mod_i = MOD_W'(m); frac_i = (MOD_W+1)'(f);
    sdm_en_i = sdm; dither_en_i = dith; low_rate_i = low; low_sel_i = 2'(sel);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // measure one period from the current pulse negedge to the next
  task automatic run_one(output int per, output int dv);
    per = 0; dv = -1;
    do begin
      @(negedge clk_i);
      per++;
      if (per == 1) dv = int'(div_val_o);
    end while (!div_pulse_o && per < 300);
    if (per >= 300) chk(0, "R2", "period timeout", per, 0);
  endtask

  task automatic run(int t, output longint sum, output int mn, output int mx, output int bad);
    int per, dv;
    sum = 0; mn = 1000; mx = -1; bad = 0;
    for (int i = 0; i < t; i++) begin
      run_one(per, dv);
      sum += per;
      if (per < mn) mn = per;
      if (per > mx) mx = per;
      if (dv != per) bad++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      chk(0, "WDOG", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint sum, exp;
    int mn, mx, bad, per, dv;
    int rec[10];

    // R1 reset state
    start(5, 1, 0, 0, 0, 0, 0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(div_val_o == 1, "R1", "div_val in reset", div_val_o, 1);
    chk(div_pulse_o == 1, "R1", "pulse in reset", div_pulse_o, 1);
    @(negedge clk_i) rst_ni = 1'b1;
    chk(div_pulse_o == 1, "R1", "first pulse after release", div_pulse_o, 1);

    // R3 integer mode, all N
    for (int n = 0; n < 64; n++) begin
      start(n, 1, 0, 0, 0, 0, 0);
      run(3, sum, mn, mx, bad);
      exp = 3 * ((n == 0) ? 1 : n);
      chk(sum == exp && mn == mx, "R3", $sformatf("int sum n=%0d", n), sum, exp);
      chk(bad == 0, "R2", "value vs spacing", bad, 0);
    end

    // R4/R5 sweep over small moduli and every legal fraction
    foreach (rec[i]) rec[i] = 0;
    for (int mi = 0; mi < 3; mi++) begin
      for (int ni = 0; ni < 2; ni++) begin
        automatic int m = (mi == 0) ? 3 : (mi == 1) ? 5 : 8;
        automatic int n = (ni == 0) ? 4 : 9;
        for (int f = -(m - 1); f < m; f++) begin
          automatic int t = 2 * m * 3;
          start(n, m, f, 1, 0, 0, 0);
          run(t, sum, mn, mx, bad);
          exp = longint'(t) * n + (longint'(t) * (m + f)) / (2 * m);
          chk(sum == exp || sum == exp + 1, "R4", $sformatf("sum m=%0d n=%0d f=%0d", m, n, f), sum, exp);
          chk(mn >= n - 1 && mx <= n + 2, "R5", "period window", mx, n + 2);
          chk(bad == 0, "R2", "value vs spacing", bad, 0);
        end
      end
    end

    // R6 small integer part acts as 4
    start(2, 5, 0, 1, 0, 0, 0);
    run(10, sum, mn, mx, bad);
    chk(sum == 45 || sum == 46, "R6", "n<4 treated as 4", sum, 45);

    // R5 cap at 63
    start(63, 5, 4, 1, 0, 0, 0);
    run(40, sum, mn, mx, bad);
    chk(mx <= 63 && mn >= 62, "R5", "cap at max", mx, 63);

    // R4 typical vectors
    start(23, 130000, 110800, 1, 0, 0, 0);
    run(300, sum, mn, mx, bad);
    exp = 300 * 23 + (longint'(300) * 240800) / 260000;
    chk(sum == exp || sum == exp + 1, "R4", "vector n=23", sum, exp);
    start(24, 130000, -120000, 1, 0, 0, 0);
    run(300, sum, mn, mx, bad);
    exp = 300 * 24 + (longint'(300) * 10000) / 260000;
    chk(sum == exp || sum == exp + 1, "R4", "vector n=24", sum, exp);
    chk(mn >= 23 && mx <= 26, "R5", "window n=24", mn, 23);

    // R7 dither raises the numerator
    start(6, 5, 0, 1, 1, 0, 0);
    run(200, sum, mn, mx, bad);
    chk(sum >= 1302, "R7", "dithered sum", sum, 1302);
    chk(mn >= 5 && mx <= 8, "R7", "dithered window", mx, 8);

    // R8 low-rate ratios, modulator and int ignored
    for (int s = 0; s < 4; s++) begin
      start(20, 5, 3, 1, 1, 1, s);
      run(4, sum, mn, mx, bad);
      exp = 4 * ((s == 0) ? 1 : (s == 1) ? 2 : 4);
      chk(sum == exp && mn == mx, "R8", $sformatf("low sel=%0d", s), sum, exp);
    end

    // R9 mid-period change vs change in the pulse cycle
    start(5, 1, 0, 0, 0, 0, 0);
    run(1, sum, mn, mx, bad);
    @(negedge clk_i); @(negedge clk_i);
    int_i = 6'd9;
    per = 2;
    do begin @(negedge clk_i); per++; end while (!div_pulse_o && per < 300);
    chk(per == 5, "R9", "mid-period change ignored", per, 5);
    run_one(per, dv);
    chk(per == 9, "R9", "next period uses new value", per, 9);
    int_i = 6'd7;
    run_one(per, dv);
    chk(per == 7, "R9", "change in pulse cycle", per, 7);

    // R10 leaving fractional mode clears the accumulators
    start(6, 5, 3, 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) begin run_one(per, dv); rec[i] = per; end
    run(7, sum, mn, mx, bad);
    sdm_en_i = 1'b0;
    run(2, sum, mn, mx, bad);
    chk(sum == 12, "R10", "integer periods while off", sum, 12);
    sdm_en_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      run_one(per, dv);
      chk(per == rec[i], "R10", $sformatf("restart period %0d", i), per, rec[i]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule